// File: doc/BRIEF.md
# Three-Buffer Frame Rotation Arbiter

This block shares one 4 KB window between a USB transfer engine and a consumer processor. The window is split into three buffers of equal size. On each 1 ms frame tick, the roles move on by one step. During a frame, the engine writes received data into one buffer and fetches outgoing data from a second. The consumer owns the third buffer: it first drains that buffer and then refills it for a later frame. The block gives out the base address of every role and raises a one-cycle frame interrupt toward the consumer.

Every engine access is a request that carries a byte length. The block keeps a byte budget for each direction. A request that fits in its budget is acknowledged together with the buffer address where its data goes. A request that would take either direction past the per-frame cap is refused. Once that happens, all traffic in both directions stops until the next tick. A sticky flag records the cut, and the consumer clears it by reading it. Only addresses and lengths are modelled. Data contents are not.

Top module: `frame_rot_arb`

## Requirements
- R1: Buffers sit at byte offsets 0 (A), 1360 (B) and 2720 (C). Reset puts the block in frame phase 0. In phase 0 the engine writes B, reads C and the consumer owns A. In phase 1 the engine writes C, reads A and the consumer owns B. In phase 2 the engine writes A, reads B and the consumer owns C. Each `frame_tick_i` moves the phase on, and phase 2 returns to phase 0. The base outputs change in the cycle after the tick edge.
- R2: `frame_irq_o` is high for exactly the one cycle after each edge where `frame_tick_i` was sampled high.
- R3: An accepted request is acknowledged one cycle later. Its address output equals the active role base plus the bytes already accepted in that direction during the current frame.
- R4: A direction accepts requests as long as its running total stays at or below 1360 bytes. For example, twenty 68-byte writes are all accepted, the last one at base+1292.
- R5: A request that would take its direction's total above 1360 is refused and halts the frame (`halted_o`=1). While the frame is halted, both directions refuse every request, including requests of length zero.
- R6: A frame tick clears the halt and both byte totals.
- R7: `ovf_o` is set in the cycle after a refusal that halts the frame. It stays set across frame ticks and clears in the cycle after `ovf_clr_i`. If a new refusal and `ovf_clr_i` fall in the same cycle, the flag stays set.
- R8: A request sampled on the same edge as `frame_tick_i` belongs to the new frame. It is judged against empty totals with no halt, and it is placed at the new phase's base.
- R9: If a write and a read arrive together and either one would exceed its cap, neither is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_tick_i | input | 1 | 1 ms frame boundary strobe |
| eng_wr_req_i | input | 1 | Engine write (receive) request |
| eng_wr_len_i | input | LEN_W | Write length in bytes |
| eng_rd_req_i | input | 1 | Engine read (send) request |
| eng_rd_len_i | input | LEN_W | Read length in bytes |
| ovf_clr_i | input | 1 | Consumer read of the overflow flag; clears it |
| eng_wr_ack_o | output | 1 | Write request accepted |
| eng_wr_addr_o | output | ADDR_W | Window address for the accepted write |
| eng_rd_ack_o | output | 1 | Read request accepted |
| eng_rd_addr_o | output | ADDR_W | Window address for the accepted read |
| eng_wr_base_o | output | ADDR_W | Base of the engine write buffer |
| eng_rd_base_o | output | ADDR_W | Base of the engine read buffer |
| cpu_base_o | output | ADDR_W | Base of the consumer buffer |
| frame_irq_o | output | 1 | Frame interrupt pulse |
| halted_o | output | 1 | Traffic stopped for the rest of the frame |
| ovf_o | output | 1 | Sticky frame-cut flag |

## Verification
Two events can land on the same clock edge. In the first case, a refusal that sets the overflow flag arrives together with the consumer's clear. The bench sends an oversized write in the same cycle as `ovf_clr_i` and expects the flag to stay high. In the second case, a frame tick arrives together with a request while the frame is halted. The bench holds a halted frame, raises the tick and a 100-byte write together, and expects the write to be acknowledged at offset 0 of the newly rotated write buffer. It also checks that a follow-up write lands right after it.

// File: rtl/frame_rot_pkg.sv
package frame_rot_pkg;
  localparam int unsigned NUM_BUF = 3;
  typedef logic [1:0] phase_t;

  function automatic phase_t phase_step(phase_t p);
    return (p == phase_t'(NUM_BUF - 1)) ? phase_t'(0) : phase_t'(p + 2'd1);
  endfunction

  // buffer index that the role takes in a phase: role 0 cpu, 1 write, 2 read
  function automatic phase_t role_buf(phase_t p, int unsigned role);
    int unsigned s;
    s = (int'(p) + role) % NUM_BUF;
    return phase_t'(s);
  endfunction
endpackage

// File: rtl/frame_phase_ctr.sv
module frame_phase_ctr
  import frame_rot_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 1360,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [ADDR_W-1:0] cpu_base_o,
  output logic [ADDR_W-1:0] wr_base_o,
  output logic [ADDR_W-1:0] rd_base_o,
  output logic [ADDR_W-1:0] wr_base_eff_o,
  output logic [ADDR_W-1:0] rd_base_eff_o,
  output logic              irq_o
);
  phase_t phase_q, phase_eff;
  logic [NUM_BUF-1:0][ADDR_W-1:0] base_tab;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_base
    assign base_tab[g] = ADDR_W'(g * BUF_BYTES);
  end

  assign phase_eff = tick_i ? phase_step(phase_q) : phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      irq_o   <= 1'b0;
    end else begin
      phase_q <= phase_eff;
      irq_o   <= tick_i;
    end
  end

  assign cpu_base_o    = base_tab[role_buf(phase_q, 0)];
  assign wr_base_o     = base_tab[role_buf(phase_q, 1)];
  assign rd_base_o     = base_tab[role_buf(phase_q, 2)];
  assign wr_base_eff_o = base_tab[role_buf(phase_eff, 1)];
  assign rd_base_eff_o = base_tab[role_buf(phase_eff, 2)];

  p_phase_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= phase_t'(NUM_BUF - 1));
  p_phase_moves_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> phase_q != $past(phase_q));
  p_irq_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> irq_o);
  p_irq_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !irq_o);
endmodule

// File: rtl/byte_budget.sv
module byte_budget #(
  parameter int unsigned LIMIT = 1360,
  parameter int unsigned LEN_W = 11,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1),
  localparam int unsigned SUM_W = CNT_W + LEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             go_i,
  output logic             fit_o,
  output logic [CNT_W-1:0] cnt_eff_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum;

  assign cnt_eff_o = clr_i ? '0 : cnt_q;
  assign sum       = SUM_W'(cnt_eff_o) + SUM_W'(len_i);
  assign fit_o     = sum <= SUM_W'(LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (req_i && go_i)      cnt_q <= CNT_W'(sum);
    else if (req_i && !fit_o)    cnt_q <= CNT_W'(LIMIT);  // saturate on cut
    else                         cnt_q <= cnt_eff_o;
  end

  p_cnt_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(LIMIT));
  p_clr_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !req_i) |=> cnt_q == '0);
endmodule

// File: rtl/frame_rot_arb.sv
module frame_rot_arb
  import frame_rot_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 1360,
  parameter int unsigned LEN_W     = 11,
  localparam int unsigned ADDR_W   = $clog2(NUM_BUF * BUF_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_tick_i,
  input  logic              eng_wr_req_i,
  input  logic [LEN_W-1:0]  eng_wr_len_i,
  input  logic              eng_rd_req_i,
  input  logic [LEN_W-1:0]  eng_rd_len_i,
  input  logic              ovf_clr_i,
  output logic              eng_wr_ack_o,
  output logic [ADDR_W-1:0] eng_wr_addr_o,
  output logic              eng_rd_ack_o,
  output logic [ADDR_W-1:0] eng_rd_addr_o,
  output logic [ADDR_W-1:0] eng_wr_base_o,
  output logic [ADDR_W-1:0] eng_rd_base_o,
  output logic [ADDR_W-1:0] cpu_base_o,
  output logic              frame_irq_o,
  output logic              halted_o,
  output logic              ovf_o
);
  localparam int unsigned CNT_W = $clog2(BUF_BYTES + 1);

  logic [ADDR_W-1:0] wr_base_eff, rd_base_eff;
  logic [1:0]                  req, fit;
  logic [1:0][LEN_W-1:0]       len;
  logic [1:0][CNT_W-1:0]       cnt_eff;
  logic [1:0][ADDR_W-1:0]      base_eff;
  logic halt_eff, cut, go;

  frame_phase_ctr #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)) u_phase (
    .clk_i, .rst_ni, .tick_i(frame_tick_i),
    .cpu_base_o(cpu_base_o), .wr_base_o(eng_wr_base_o), .rd_base_o(eng_rd_base_o),
    .wr_base_eff_o(wr_base_eff), .rd_base_eff_o(rd_base_eff), .irq_o(frame_irq_o)
  );

  // index 0 = engine write, 1 = engine read
  assign req      = {eng_rd_req_i, eng_wr_req_i};
  assign len      = {eng_rd_len_i, eng_wr_len_i};
  assign base_eff = {rd_base_eff, wr_base_eff};

  assign halt_eff = halted_o && !frame_tick_i;
  assign cut      = !halt_eff && |(req & ~fit);
  assign go       = !halt_eff && !cut;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    byte_budget #(.LIMIT(BUF_BYTES), .LEN_W(LEN_W)) u_budget (
      .clk_i, .rst_ni, .clr_i(frame_tick_i), .req_i(req[d]), .len_i(len[d]),
      .go_i(go), .fit_o(fit[d]), .cnt_eff_o(cnt_eff[d])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eng_wr_ack_o  <= 1'b0;
      eng_rd_ack_o  <= 1'b0;
      eng_wr_addr_o <= '0;
      eng_rd_addr_o <= '0;
      halted_o      <= 1'b0;
      ovf_o         <= 1'b0;
    end else begin
      eng_wr_ack_o <= go && req[0];
      eng_rd_ack_o <= go && req[1];
      if (go && req[0]) eng_wr_addr_o <= base_eff[0] + ADDR_W'(cnt_eff[0]);
      if (go && req[1]) eng_rd_addr_o <= base_eff[1] + ADDR_W'(cnt_eff[1]);
      halted_o <= halt_eff || cut;
      if (cut)            ovf_o <= 1'b1;  // set beats clear
      else if (ovf_clr_i) ovf_o <= 1'b0;
    end
  end

  p_no_ack_halted_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !frame_tick_i) |=> !(eng_wr_ack_o || eng_rd_ack_o));
  p_ovf_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cut |=> ovf_o);
  p_tick_unhalts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_tick_i && !eng_wr_req_i && !eng_rd_req_i) |=> !halted_o);
  p_pair_refused_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cut |=> !(eng_wr_ack_o || eng_rd_ack_o));
endmodule

// File: tb/tb_frame_rot_arb.sv
module tb_frame_rot_arb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic frame_tick_i = 0, eng_wr_req_i = 0, eng_rd_req_i = 0, ovf_clr_i = 0;
  logic [10:0] eng_wr_len_i = '0, eng_rd_len_i = '0;
  logic eng_wr_ack_o, eng_rd_ack_o, frame_irq_o, halted_o, ovf_o;
  logic [11:0] eng_wr_addr_o, eng_rd_addr_o, eng_wr_base_o, eng_rd_base_o, cpu_base_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  frame_rot_arb dut (.*, .clk_i(clk));

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at negedge, sample registered outputs at the following negedge
  task automatic cyc(bit t, bit w, int wl, bit r, int rl, bit c);
    frame_tick_i = t; eng_wr_req_i = w; eng_wr_len_i = 11'(wl);
    eng_rd_req_i = r; eng_rd_len_i = 11'(rl); ovf_clr_i = c;
    @(negedge clk);
    frame_tick_i = 0; eng_wr_req_i = 0; eng_rd_req_i = 0; ovf_clr_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 cpu base", cpu_base_o, 0);
    chk("R1 wr base", eng_wr_base_o, 1360);
    chk("R1 rd base", eng_rd_base_o, 2720);
    chk("R5 halted reset", halted_o, 0);
    chk("R7 ovf reset", ovf_o, 0);
    chk("R2 irq reset", frame_irq_o, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 20; i++) begin
      cyc(0, 1, 68, 0, 0, 0);
      chk("R4 wr ack", eng_wr_ack_o, 1);
      chk("R3 wr addr", eng_wr_addr_o, 1360 + 68 * i);
    end
    for (int i = 0; i < 19; i++) begin
      cyc(0, 0, 0, 1, 64, 0);
      chk("R3 rd addr", eng_rd_addr_o, 2720 + 64 * i);
    end
    chk("R4 halted after exact fill", halted_o, 0);
  endtask

  task automatic t_cut();
    cyc(0, 0, 0, 1, 145, 0);
    chk("R5 over-cap refused", eng_rd_ack_o, 0);
    chk("R5 halted", halted_o, 1);
    chk("R7 ovf set", ovf_o, 1);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R5 zero write refused", eng_wr_ack_o, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R5 zero read refused", eng_rd_ack_o, 0);
  endtask

  task automatic t_tick();
    cyc(1, 0, 0, 0, 0, 0);
    chk("R2 irq high", frame_irq_o, 1);
    chk("R6 halt cleared", halted_o, 0);
    chk("R1 cpu base ph1", cpu_base_o, 1360);
    chk("R1 wr base ph1", eng_wr_base_o, 2720);
    chk("R1 rd base ph1", eng_rd_base_o, 0);
    chk("R7 ovf sticky over tick", ovf_o, 1);
    cyc(0, 1, 1360, 0, 0, 0);
    chk("R2 irq single cycle", frame_irq_o, 0);
    chk("R6 full budget after tick", eng_wr_ack_o, 1);
    chk("R6 write at base", eng_wr_addr_o, 2720);
  endtask

  task automatic t_ovf_clear();
    cyc(0, 0, 0, 0, 0, 1);
    chk("R7 ovf cleared on read", ovf_o, 0);
    cyc(0, 1, 1, 0, 0, 1);
    chk("R7 set wins over clear", ovf_o, 1);
    chk("R5 halted on cut", halted_o, 1);
  endtask

  task automatic t_tick_collide();
    cyc(1, 1, 100, 0, 0, 0);
    chk("R8 write with tick acked", eng_wr_ack_o, 1);
    chk("R8 write at new base", eng_wr_addr_o, 0);
    chk("R1 cpu base ph2", cpu_base_o, 2720);
    chk("R1 rd base ph2", eng_rd_base_o, 1360);
    cyc(0, 1, 10, 0, 0, 0);
    chk("R3 next write offset", eng_wr_addr_o, 100);
  endtask

  task automatic t_pair();
    cyc(0, 1, 1250, 1, 1361, 0);
    chk("R9 fitting write refused", eng_wr_ack_o, 0);
    chk("R9 read refused", eng_rd_ack_o, 0);
    chk("R9 halted", halted_o, 1);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R1 wrap cpu", cpu_base_o, 0);
    chk("R1 wrap wr", eng_wr_base_o, 1360);
    chk("R1 wrap rd", eng_rd_base_o, 2720);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_cut();
    t_tick();
    t_ovf_clear();
    t_tick_collide();
    t_pair();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule